// File: doc/BRIEF.md
# Tree Up-Down Next-Hop Selector

This block picks the output port of one switch in a k-ary tree, or in a fat tree, where the radix k is a power of two. Every end node has an address made of n digits in radix k. Each digit is `RADIX_LOG2` bits wide, and the top digit names the branch taken just under the root. A switch at level L sits L levels above the leaves. Leaf switches are at level 0 and the root is at level n-1. The number of ports on a switch does not depend on the size of the network.

Each cycle the block may receive one header: a strobe, the source and destination addresses, and the level of the switch. It XORs the two addresses. The highest nonzero digit of that relative address is the turn level, where the packet stops climbing and starts descending.

- A switch below the turn level sends the packet up.
- A switch at or above the turn level sends it down the child port named by the destination digit for its own level.
- Identical addresses go to the local port.

When `PARENTS` is above one there are several parent links, and a round-robin pointer chooses among them. The pointer moves only when a valid header is routed upward.

The decision is held in a small state register whose state is the kind of port selected:

- `RS_IDLE`: no header.
- `RS_LOCAL`: deliver locally.
- `RS_DOWN`: a child port.
- `RS_UP`: a parent port.

The register moves every cycle. From any state it goes to `RS_IDLE` when the strobe is low. Otherwise it goes to `RS_LOCAL`, `RS_DOWN` or `RS_UP`, following the header decision. The register and the port index therefore show the result one cycle after the strobe.

Top module: `tree_updown_route`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0, `out_kind` is 2'b00 and `out_port` is 0. The round-robin pointer restarts so that the first upward header after reset leaves on parent 0.
- R2: `out_valid` in a cycle equals `hdr_valid` of the cycle before: the result of a header sampled at one rising edge is visible after that edge.
- R3: A valid header whose source equals its destination yields `out_kind` 2'b11 (local) and `out_port` 0.
- R4: The turn level is the index of the most significant nonzero digit of source XOR destination, where digit d is bits [d*RADIX_LOG2 +: RADIX_LOG2]. A valid header with `sw_level` below the turn level yields `out_kind` 2'b10 (up).
- R5: A valid header with differing addresses and `sw_level` at or above the turn level yields `out_kind` 2'b01 (down), and `out_port` equals destination digit number `sw_level`.
- R6: Upward headers take parent indices 0, 1, …, PARENTS-1, then wrap to 0, in `out_port`. Down, local and idle cycles do not move the pointer.
- R7: With no header, the next cycle shows `out_kind` 2'b00 and `out_port` 0.
- R8: An upward `out_port` is always below `PARENTS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | A header is present this cycle |
| src_addr | input | RADIX_LOG2*DIGITS | Source node address |
| dst_addr | input | RADIX_LOG2*DIGITS | Destination node address |
| sw_level | input | LVL_W | Level of this switch, 0 at the leaves |
| out_valid | output | 1 | Registered selection is valid |
| out_kind | output | 2 | 00 none, 01 down, 10 up, 11 local |
| out_port | output | IDX_W | Child digit or parent index |

## Verification
The assertions assume three things about the inputs:

- `hdr_valid` is held low during reset.
- `sw_level` lies below `DIGITS`.
- Address inputs carry known values from time zero.

The stimulus drives all inputs to zero before reset is released. It only sets levels from 0 to 2 for a three-digit tree. It changes inputs on falling edges, so every header is sampled cleanly at one rising edge. The scoreboard keeps its own round-robin count, which is cleared at each reset, to predict the parent index.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'b00,
        RS_DOWN  = 2'b01,
        RS_UP    = 2'b10,
        RS_LOCAL = 2'b11
    } route_state_t;

endpackage

// File: rtl/tree_turn_finder.sv
module tree_turn_finder #(
    parameter int RADIX_LOG2 = 2,
    parameter int DIGITS     = 3,
    parameter int LVL_W      = 2
) (
    input  logic [RADIX_LOG2*DIGITS-1:0] src,
    input  logic [RADIX_LOG2*DIGITS-1:0] dst,
    output logic [LVL_W-1:0]             turn_lvl,
    output logic                         differ
);
    localparam int AW = RADIX_LOG2 * DIGITS;

    logic [AW-1:0]     rel;
    logic [DIGITS-1:0] digit_nz;

    assign rel = src ^ dst;

    // one nonzero flag per radix digit of the relative address
    for (genvar d = 0; d < DIGITS; d++) begin : g_nz
        assign digit_nz[d] = |rel[d*RADIX_LOG2 +: RADIX_LOG2];
    end

    assign differ = |digit_nz;

    // highest nonzero digit wins: later loop iterations overwrite
    always_comb begin
        turn_lvl = '0;
        for (int d = 0; d < DIGITS; d++) begin
            if (digit_nz[d]) turn_lvl = LVL_W'(d);
        end
    end

    // R4: the turn digit is nonzero and nothing above it differs
    always_comb begin
        if (differ) begin
            a_r4_turn_is_top_digit: assert (
                ((rel >> (RADIX_LOG2 * (32'(turn_lvl) + 1))) == '0) &&
                ((rel >> (RADIX_LOG2 * 32'(turn_lvl))) != '0));
        end
    end

endmodule

// File: rtl/tree_parent_rr.sv
module tree_parent_rr #(
    parameter int PARENTS = 3,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    if (PARENTS == 1) begin : g_single
        assign ptr = '0;
    end else begin : g_multi
        logic [IDX_W-1:0] ptr_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q <= '0;
            end else if (advance) begin
                ptr_q <= (ptr_q == IDX_W'(PARENTS - 1)) ? '0 : ptr_q + 1'b1;
            end
        end

        assign ptr = ptr_q;

        // R6: pointer only moves on an accepted upward header
        a_r6_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !advance |=> $stable(ptr_q));
        // R8: pointer never names a missing parent
        a_r8_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            32'(ptr_q) < PARENTS);
    end

endmodule

// File: rtl/tree_updown_route.sv
module tree_updown_route
    import tree_route_pkg::*;
#(
    parameter int RADIX_LOG2 = 2,
    parameter int DIGITS     = 3,
    parameter int PARENTS    = 3,
    localparam int AW        = RADIX_LOG2 * DIGITS,
    localparam int LVL_W     = (DIGITS > 1) ? $clog2(DIGITS) : 1,
    localparam int PAR_W     = (PARENTS > 1) ? $clog2(PARENTS) : 1,
    localparam int IDX_W     = (PAR_W > RADIX_LOG2) ? PAR_W : RADIX_LOG2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_valid,
    input  logic [AW-1:0]    src_addr,
    input  logic [AW-1:0]    dst_addr,
    input  logic [LVL_W-1:0] sw_level,
    output logic             out_valid,
    output logic [1:0]       out_kind,
    output logic [IDX_W-1:0] out_port
);
    route_state_t          state_q, state_d;
    logic [IDX_W-1:0]      idx_q, idx_d;
    logic [LVL_W-1:0]      turn_lvl;
    logic                  differ;
    logic [IDX_W-1:0]      rr_ptr;
    logic                  up_fire;
    logic [RADIX_LOG2-1:0] dst_digit;

    tree_turn_finder #(
        .RADIX_LOG2 (RADIX_LOG2),
        .DIGITS     (DIGITS),
        .LVL_W      (LVL_W)
    ) u_turn (
        .src      (src_addr),
        .dst      (dst_addr),
        .turn_lvl (turn_lvl),
        .differ   (differ)
    );

    // destination digit belonging to this switch's level
    always_comb begin
        dst_digit = '0;
        for (int d = 0; d < DIGITS; d++) begin
            if (32'(sw_level) == d) dst_digit = dst_addr[d*RADIX_LOG2 +: RADIX_LOG2];
        end
    end

    // next-state decision
    always_comb begin
        state_d = RS_IDLE;
        idx_d   = '0;
        if (hdr_valid) begin
            if (!differ) begin
                state_d = RS_LOCAL;
            end else if (sw_level < turn_lvl) begin
                state_d = RS_UP;
                idx_d   = rr_ptr;
            end else begin
                state_d = RS_DOWN;
                idx_d   = IDX_W'(dst_digit);
            end
        end
    end

    assign up_fire = (state_d == RS_UP);

    tree_parent_rr #(
        .PARENTS (PARENTS),
        .IDX_W   (IDX_W)
    ) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (up_fire),
        .ptr     (rr_ptr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // outputs from state
    always_comb begin
        unique case (state_q)
            RS_IDLE: begin
                out_valid = 1'b0;
                out_kind  = 2'b00;
                out_port  = '0;
            end
            RS_DOWN: begin
                out_valid = 1'b1;
                out_kind  = 2'b01;
                out_port  = idx_q;
            end
            RS_UP: begin
                out_valid = 1'b1;
                out_kind  = 2'b10;
                out_port  = idx_q;
            end
            RS_LOCAL: begin
                out_valid = 1'b1;
                out_kind  = 2'b11;
                out_port  = '0;
            end
            default: begin
                out_valid = 1'b0;
                out_kind  = 2'b00;
                out_port  = '0;
            end
        endcase
    end

    // R2: a header shows up exactly one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> out_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !out_valid);
    // R3: equal addresses leave through the local port
    a_r3_local: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && (src_addr == dst_addr)) |=> (out_kind == 2'b11 && out_port == '0));
    // R4: differing addresses never go local
    a_r4_not_local: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && (src_addr != dst_addr)) |=> (out_kind != 2'b11));
    // R7: idle cycles clear the selection
    a_r7_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> (out_kind == 2'b00 && out_port == '0));
    // R8: an upward selection names an existing parent
    a_r8_up_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_kind == 2'b10) |-> (32'(out_port) < PARENTS));

endmodule

// File: tb/tb_tree_updown_route.sv
module tb_tree_updown_route;

    localparam int B  = 2;
    localparam int N  = 3;
    localparam int P  = 3;
    localparam int AW = B * N;

    typedef struct {
        logic       v;
        logic [1:0] kind;
        logic [1:0] port;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hdr_valid = 1'b0;
    logic [AW-1:0] src_addr = '0;
    logic [AW-1:0] dst_addr = '0;
    logic [1:0]    sw_level = '0;
    logic          out_valid;
    logic [1:0]    out_kind;
    logic [1:0]    out_port;

    int   checks = 0;
    int   errors = 0;
    int   model_ptr = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    tree_updown_route #(.RADIX_LOG2(B), .DIGITS(N), .PARENTS(P)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_valid (hdr_valid),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr),
        .sw_level  (sw_level),
        .out_valid (out_valid),
        .out_kind  (out_kind),
        .out_port  (out_port)
    );

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push the prediction
    task automatic drive(input logic v, input logic [AW-1:0] s, input logic [AW-1:0] d,
                         input int lvl, input string tag);
        exp_t e;
        int   turn;
        @(negedge clk);
        hdr_valid = v;
        src_addr  = s;
        dst_addr  = d;
        sw_level  = 2'(lvl);
        e.tag = tag;
        e.v   = v;
        e.kind = 2'b00;
        e.port = 2'b00;
        if (v) begin
            turn = -1;
            for (int k = 0; k < N; k++) if (((s ^ d) >> (B * k)) & 2'b11) turn = k;
            if (turn < 0) begin
                e.kind = 2'b11;
            end else if (lvl < turn) begin
                e.kind = 2'b10;
                e.port = 2'(model_ptr);
                model_ptr = (model_ptr + 1) % P;
            end else begin
                e.kind = 2'b01;
                e.port = 2'((d >> (B * lvl)) & 2'b11);
            end
        end
        sb.push_back(e);
    endtask

    // monitor: compare one result after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {out_valid, out_kind, out_port}, {e.v, e.kind, e.port});
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        hdr_valid = 1'b0;
        rst_n = 1'b0;
        model_ptr = 0;
        repeat (2) @(negedge clk);
        check("R1 in reset", {out_valid, out_kind, out_port}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {out_valid, out_kind, out_port}, 5'b0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: first upward header after reset uses parent 0
        drive(1, 6'h00, 6'h27, 0, "R1 first up parent0");
        // R3: equal addresses go local
        drive(1, 6'h15, 6'h15, 0, "R3 local");
        drive(1, 6'h3F, 6'h3F, 2, "R3 local at root level");
        // R7: idle cycle clears outputs, R2 no valid
        drive(0, 6'h00, 6'h27, 0, "R7 idle");
        // R5: turn at digit 0, leaf switch goes down on dst digit 0
        drive(1, 6'h01, 6'h02, 0, "R5 down digit0");
        // R4: turn at digit 2, level 1 goes up (parent 1)
        drive(1, 6'h00, 6'h27, 1, "R4 up level1");
        // R5: level 2 at turn 2, down on digit2 = 2
        drive(1, 6'h00, 6'h27, 2, "R5 down at root");
        // R5: turn 1, level 1 down on digit1 = 3
        drive(1, 6'h00, 6'h0D, 1, "R5 down digit1");
        // R5: level above turn still goes down on its own digit
        drive(1, 6'h00, 6'h0D, 2, "R5 down above turn");
        // R4: turn 1, level 0 up (parent 2)
        drive(1, 6'h00, 6'h0D, 0, "R4 up level0");
        // R6: wrap to parent 0, then 1, down/local/idle in between do not advance
        drive(1, 6'h30, 6'h00, 0, "R6 wrap to 0");
        drive(1, 6'h30, 6'h31, 0, "R6 down no advance");
        drive(1, 6'h22, 6'h22, 1, "R6 local no advance");
        drive(0, 6'h30, 6'h00, 0, "R6 idle no advance");
        drive(1, 6'h30, 6'h00, 1, "R6 next parent1");
        drive(1, 6'h30, 6'h00, 0, "R6 next parent2");
        // R8: back to back ups stay in range
        for (int i = 0; i < 6; i++) drive(1, 6'h2A, 6'h15, i % 2, "R8 up in range");
        drive(0, 6'h00, 6'h00, 0, "R2 trailing idle");
        repeat (3) @(negedge clk);
        // R1: reset mid-stream restarts the pointer
        drive(1, 6'h00, 6'h27, 0, "R6 advance before reset");
        repeat (3) @(negedge clk);
        do_reset();
        drive(1, 6'h00, 6'h27, 0, "R1 pointer restart");
        drive(0, 6'h00, 6'h00, 0, "R2 final idle");
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule